// File: doc/BRIEF.md
# Transition Count Window Checker

This block is a synthesizable monitor that counts how often a single-bit signal changes value inside a window. The window is framed by two marker inputs. A rising edge on the start marker opens it. The first cycle in which the end marker is high closes it. The number of changes required for a pass is not fixed at build time. It arrives on a runtime input and is captured when the window opens.

When the window closes, the block reports the result as a one-cycle pass pulse or a one-cycle error pulse. It does not wait for the end marker when the count is already at the limit and yet another change arrives. In that case it raises the error at once and abandons the window. Only one window is tracked at a time. A running count output shows how many changes the current or most recent window has seen.

Top module: `toggle_window_checker`

## Requirements
- R1: A window opens on a clock edge where `mark_b` is high and was low at the previous edge, while no window is open. At that edge the value of `sig_a` becomes the reference, `req_cnt` is captured, and `cnt_o` is cleared to 0. After reset `mark_b` is taken as previously low.
- R2: While a window is open, each edge at which `sig_a` differs from its value at the previous edge adds one to `cnt_o`.
- R3: The window closes at the first edge after opening at which `mark_c` is high. In the next cycle exactly one of `pass_o` or `err_o` is high for one cycle: `pass_o` when the final count equals the captured requirement, otherwise `err_o`.
- R4: If `sig_a` changes while the count already equals the captured requirement and `mark_c` is low, `err_o` pulses in the next cycle and the window is abandoned. `cnt_o` then reads the requirement plus one.
- R5: A change of `sig_a` at the closing edge is counted before the final comparison.
- R6: A rising edge of `mark_b` while a window is open neither restarts the window nor clears the count.
- R7: Changes on `req_cnt` while a window is open do not affect that window's result.
- R8: Reset is synchronous and active low. It closes any open window, clears `cnt_o` to 0 and holds `pass_o` and `err_o` low.
- R9: While no window is open, changes on `sig_a` and a high `mark_c` produce no pulse and leave `cnt_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sig_a | input | 1 | Signal whose changes are counted |
| mark_b | input | 1 | Start marker; a rising edge opens a window |
| mark_c | input | 1 | End marker; high closes the open window |
| req_cnt | input | CNT_W | Required number of changes, captured at opening |
| pass_o | output | 1 | One-cycle pulse: the window closed with the exact count |
| err_o | output | 1 | One-cycle pulse: count mismatch at close, or early overrun |
| cnt_o | output | CNT_W | Changes counted in the current or last window |

## Verification
The embedded properties check several rules on every cycle:
- pass and error never pulse together;
- no pulse follows a cycle without an open window;
- every close or overrun is followed by a pulse;
- the count never passes the captured requirement while the window is open;
- the captured requirement stays constant within a window;
- a second start edge keeps the window open.

Only the bench's scenarios can show whether the reported verdict matches the intended number of changes. They cover several requirements, spacings and end-cycle changes. They also show that changes to the requirement input mid-window are ignored and that a reset in mid-window leaves nothing behind.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_OPEN = 1'b1
  } win_state_t;

  // One change when the present sample differs from the stored one
  function automatic logic is_change(input logic now_v, input logic ref_v);
    return now_v ^ ref_v;
  endfunction

  // Count after this cycle's change, if any
  function automatic logic [31:0] bump(input logic [31:0] cur, input logic chg);
    return cur + {31'd0, chg};
  endfunction

endpackage

// File: rtl/tcw_edge.sv
module tcw_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
endmodule

// File: rtl/tcw_tracker.sv
module tcw_tracker
  import tcw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic             sig_a,
  input  logic [CNT_W-1:0] req,
  output logic             chg,
  output logic             at_limit,
  output logic             match_next,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] k_hold
);
  localparam int PAD = 32 - CNT_W;

  logic             ref_a;
  logic [CNT_W-1:0] cnt_nxt;
  logic [31:0]      wide_nxt;

  assign chg        = is_change(sig_a, ref_a);
  assign wide_nxt   = bump({{PAD{1'b0}}, count}, chg);
  assign cnt_nxt    = wide_nxt[CNT_W-1:0];
  assign at_limit   = (count == k_hold);
  assign match_next = (wide_nxt == {{PAD{1'b0}}, k_hold});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_a  <= 1'b0;
      count  <= '0;
      k_hold <= '0;
    end else if (load) begin
      ref_a  <= sig_a;
      count  <= '0;
      k_hold <= req;
    end else if (adv) begin
      ref_a  <= sig_a;
      count  <= cnt_nxt;
    end
  end

  AST_K_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && $past(adv)) |-> $stable(k_hold)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (count <= k_hold)); // R4
endmodule

// File: rtl/tcw_ctrl.sv
module tcw_ctrl
  import tcw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic b_rise,
  input  logic mark_c,
  input  logic chg,
  input  logic at_limit,
  input  logic match_next,
  output logic load,
  output logic win_open,
  output logic close_evt,
  output logic abort_evt,
  output logic pass_o,
  output logic err_o
);
  win_state_t st;

  assign win_open  = (st == ST_OPEN);
  assign load      = !win_open && b_rise;
  assign close_evt = win_open && mark_c;
  assign abort_evt = win_open && !mark_c && chg && at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      pass_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      pass_o <= close_evt && match_next;
      err_o  <= (close_evt && !match_next) || abort_evt;
      if (load)                        st <= ST_OPEN;
      else if (close_evt || abort_evt) st <= ST_IDLE;
    end
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && err_o)); // R3
  AST_VERDICT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (close_evt || abort_evt) |=> (pass_o || err_o)); // R3
  AST_NO_IDLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> (!pass_o && !err_o)); // R9
  AST_EARLY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (err_o && !win_open)); // R4
  AST_REOPEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && b_rise && !close_evt && !abort_evt) |=> win_open); // R6
endmodule

// File: rtl/toggle_window_checker.sv
module toggle_window_checker
  import tcw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_a,
  input  logic             mark_b,
  input  logic             mark_c,
  input  logic [CNT_W-1:0] req_cnt,
  output logic             pass_o,
  output logic             err_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             b_rise;
  logic             load;
  logic             win_open;
  logic             close_evt;
  logic             abort_evt;
  logic             chg;
  logic             at_limit;
  logic             match_next;
  logic [CNT_W-1:0] k_hold;

  tcw_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  (mark_b),
    .rise (b_rise)
  );

  tcw_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .adv       (win_open),
    .sig_a     (sig_a),
    .req       (req_cnt),
    .chg       (chg),
    .at_limit  (at_limit),
    .match_next(match_next),
    .count     (cnt_o),
    .k_hold    (k_hold)
  );

  tcw_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .b_rise    (b_rise),
    .mark_c    (mark_c),
    .chg       (chg),
    .at_limit  (at_limit),
    .match_next(match_next),
    .load      (load),
    .win_open  (win_open),
    .close_evt (close_evt),
    .abort_evt (abort_evt),
    .pass_o    (pass_o),
    .err_o     (err_o)
  );

  AST_OPEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_o == '0 && k_hold == $past(req_cnt))); // R1
endmodule

// File: tb/toggle_window_checker_tb.sv
module toggle_window_checker_tb;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sig_a = 1'b0;
  logic          mark_b = 1'b0;
  logic          mark_c = 1'b0;
  logic [CW-1:0] req_cnt = '0;
  logic          pass_o, err_o;
  logic [CW-1:0] cnt_o;

  int n_chk = 0, n_bad = 0;
  int pass_seen = 0, err_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  toggle_window_checker #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sig_a(sig_a), .mark_b(mark_b),
    .mark_c(mark_c), .req_cnt(req_cnt), .pass_o(pass_o),
    .err_o(err_o), .cnt_o(cnt_o)
  );

  always @(negedge clk) begin
    if (pass_o) pass_seen++;
    if (err_o)  err_seen++;
  end

  typedef struct packed { int k; int n; int g; int t; } vec_t;
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{4, 4, 0, 0}, '{4, 3, 1, 0}, '{4, 5, 0, 0}, '{4, 3, 0, 1}, '{4, 4, 2, 1},
    '{0, 0, 0, 0}, '{0, 1, 0, 0}, '{7, 7, 1, 0}, '{1, 0, 3, 0}, '{2, 6, 0, 0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One full window: open, nn changes spaced by gg idle cycles, close
  task automatic run_win(input int kk, input int nn, input int gg, input int tc);
    int total, ep, ee, ec;
    @(negedge clk);
    pass_seen = 0; err_seen = 0;
    mark_b = 1'b1; req_cnt = CW'(kk);
    for (int i = 0; i < nn; i++) begin
      @(negedge clk); sig_a = ~sig_a;
      repeat (gg) @(negedge clk);
    end
    @(negedge clk); mark_c = 1'b1;
    if (tc != 0) sig_a = ~sig_a;
    @(negedge clk); mark_c = 1'b0; mark_b = 1'b0;
    @(negedge clk);
    total = nn + tc;
    if (nn > kk)          begin ep = 0; ee = 1; ec = kk + 1; end // R4
    else if (total == kk) begin ep = 1; ee = 0; ec = total; end  // R3 R5
    else                  begin ep = 0; ee = 1; ec = total; end  // R3
    chk("R3 pass pulses", pass_seen, ep);
    chk("R4 err pulses", err_seen, ee);
    chk("R2 final count", int'(cnt_o), ec);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset pass", int'(pass_o), 0);
    chk("R8 reset err", int'(err_o), 0);
    chk("R8 reset count", int'(cnt_o), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++)
      run_win(VEC[v].k, VEC[v].n, VEC[v].g, VEC[v].t);

    // R6: second start edge mid-window
    @(negedge clk); pass_seen = 0; err_seen = 0; mark_b = 1; req_cnt = 2;
    @(negedge clk); sig_a = ~sig_a;
    @(negedge clk); mark_b = 0;
    @(negedge clk); mark_b = 1;
    @(negedge clk); sig_a = ~sig_a;
    @(negedge clk); mark_c = 1;
    @(negedge clk); mark_c = 0; mark_b = 0;
    @(negedge clk);
    chk("R6 pass kept", pass_seen, 1);
    chk("R6 count kept", int'(cnt_o), 2);

    // R7: requirement input changed mid-window
    @(negedge clk); pass_seen = 0; err_seen = 0; mark_b = 1; req_cnt = 3;
    @(negedge clk); req_cnt = 1; sig_a = ~sig_a;
    @(negedge clk); sig_a = ~sig_a;
    @(negedge clk); sig_a = ~sig_a;
    @(negedge clk); mark_c = 1;
    @(negedge clk); mark_c = 0; mark_b = 0;
    @(negedge clk);
    chk("R7 pass", pass_seen, 1);
    chk("R7 no err", err_seen, 0);

    // R9: idle activity ignored (count stays 3)
    pass_seen = 0; err_seen = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); sig_a = ~sig_a; mark_c = 1;
    end
    @(negedge clk); mark_c = 0;
    @(negedge clk);
    chk("R9 idle pulses", pass_seen + err_seen, 0);
    chk("R9 idle count", int'(cnt_o), 3);

    // R8: reset inside a window
    @(negedge clk); pass_seen = 0; err_seen = 0; mark_b = 1; req_cnt = 4;
    @(negedge clk); sig_a = ~sig_a;
    @(negedge clk); sig_a = ~sig_a;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; mark_b = 0;
    chk("R8 count cleared", int'(cnt_o), 0);
    @(negedge clk); mark_c = 1; sig_a = ~sig_a;
    @(negedge clk); mark_c = 0;
    @(negedge clk);
    chk("R8 window closed", pass_seen + err_seen, 0);
    chk("R8 count after", int'(cnt_o), 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule